// File: doc/BRIEF.md
# Two-pass ring broadcast bus

This block is a cycle-level model of a shared broadcast medium that carries multicast invalidate messages among N clusters. The medium is a coiled ring of 2N stages that moves one stage per clock and passes every cluster twice, always in the same cyclic order. On the outer turn a cluster may place a message into an empty passing slot. On the inner turn every cluster, the sender included, copies the passing slot onto its receive port so its cache can snoop it. One posted message therefore stands in for a burst of unicast invalidates to all sharers.

Only the holder of a single circulating grant token may write. An idle token visits clusters in rising index order, one per clock. A cluster with a pending message keeps the token while it sends a bounded burst, then passes it on. Each send port uses valid/ready. Ready is raised only for the token holder, and only when the slot beside its write point is free.

Top module: `ring_bcast_bus`

## Requirements
- R1: In reset and in the first cycle after reset no receive port shows a message, and only cluster 0 (the token's reset position) can see ready.
- R2: At most one send port shows ready in any cycle.
- R3: A send port shows ready only while its own valid is high and that cluster holds the token. A message posted by a cluster without the token is not taken until the token arrives.
- R4: While no cluster takes it, the token advances from cluster i to cluster (i+1) mod N on every clock.
- R5: The holder may have at most BURST messages accepted before the token moves on. The token moves to the next cluster in the clock after the BURST-th acceptance, or after any cycle in which the holder's valid is low.
- R6: The holder is not given ready while the slot at its write point already carries a message from a lower-numbered cluster. It keeps the token and its burst count while it waits.
- R7: A message accepted from cluster c in cycle t shows on cluster d's receive port in cycle t+1+N+d-c, carrying source id c and the sent payload.
- R8: Each accepted message is delivered exactly once to each of the N clusters, the originating cluster included. Nothing is delivered to a cluster while the slot is on its outer (write) turn.
- R9: Delivery of one message advances by one cluster per clock. A message seen on receive port d is seen on port d+1 in the next cycle, with the same source id and payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_valid | input | N_CL | Per cluster: a message is pending |
| tx_payload | input | N_CL*PAY_W | Per cluster message payload, cluster k at bits k*PAY_W upward |
| tx_ready | output | N_CL | Per cluster: message accepted this cycle |
| rx_valid | output | N_CL | Per cluster: a delivered message is present this cycle |
| rx_src | output | N_CL*IDW | Source cluster id of the delivered message, cluster k at bits k*IDW upward |
| rx_payload | output | N_CL*PAY_W | Payload of the delivered message, cluster k at bits k*PAY_W upward |

## Verification
The assertions check on every cycle that ready is exclusive and never raised without valid. They also check that the reset state holds in the first cycle after reset, that no burst goes over its limit, and that a delivered message moves port to port one clock apart with its contents unchanged. Other behaviours span many cycles and several clusters: token travel when idle, waiting on an occupied slot, the exact delivery cycle for each sender and receiver pair, and exactly-once delivery to all clusters. Only the bench's reference model can show these. It is driven through a single post, saturated traffic from every cluster, and irregular traffic.

// File: rtl/ring_bcast_bus.sv
module ring_bcast_bus #(
  parameter int N_CL  = 8,
  parameter int PAY_W = 16,
  parameter int BURST = 2,
  localparam int IDW  = (N_CL > 1) ? $clog2(N_CL) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_CL-1:0]        tx_valid,
  input  logic [N_CL*PAY_W-1:0]  tx_payload,
  output logic [N_CL-1:0]        tx_ready,
  output logic [N_CL-1:0]        rx_valid,
  output logic [N_CL*IDW-1:0]    rx_src,
  output logic [N_CL*PAY_W-1:0]  rx_payload
);
  localparam int STG  = 2 * N_CL;
  localparam int CNTW = (BURST > 1) ? $clog2(BURST + 1) : 1;

  logic             sv   [STG];
  logic [IDW-1:0]   ssrc [STG];
  logic [PAY_W-1:0] spay [STG];

  logic [IDW-1:0]   tok_at;
  logic [CNTW-1:0]  burst_n;
  logic [N_CL-1:0]  in_busy;
  logic [N_CL-1:0]  grant;
  logic             any_grant;
  logic             release_tok;

  assign any_grant   = |grant;
  assign release_tok = !tx_valid[tok_at] || (any_grant && burst_n == CNTW'(BURST - 1));
  assign tx_ready    = grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tok_at  <= '0;
      burst_n <= '0;
    end else if (release_tok) begin
      tok_at  <= (tok_at == IDW'(N_CL - 1)) ? '0 : tok_at + 1'b1;
      burst_n <= '0;
    end else if (any_grant) begin
      burst_n <= burst_n + 1'b1;
    end
  end

  for (genvar k = 0; k < N_CL; k++) begin : g_wr
    if (k == 0) begin : g_head
      assign in_busy[k] = 1'b0;
    end else begin : g_tail
      assign in_busy[k] = sv[k-1];
    end
    assign grant[k] = (tok_at == IDW'(k)) && tx_valid[k] && !in_busy[k];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sv[k]   <= 1'b0;
        ssrc[k] <= '0;
        spay[k] <= '0;
      end else if (grant[k]) begin
        sv[k]   <= 1'b1;
        ssrc[k] <= IDW'(k);
        spay[k] <= tx_payload[k*PAY_W +: PAY_W];
      end else if (k == 0) begin
        sv[k]   <= 1'b0;
        ssrc[k] <= '0;
        spay[k] <= '0;
      end else begin
        sv[k]   <= sv[(k == 0) ? 0 : k-1];
        ssrc[k] <= ssrc[(k == 0) ? 0 : k-1];
        spay[k] <= spay[(k == 0) ? 0 : k-1];
      end
    end
  end

  for (genvar k = N_CL; k < STG; k++) begin : g_rd
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sv[k]   <= 1'b0;
        ssrc[k] <= '0;
        spay[k] <= '0;
      end else begin
        sv[k]   <= sv[k-1];
        ssrc[k] <= ssrc[k-1];
        spay[k] <= spay[k-1];
      end
    end
    assign rx_valid[k-N_CL]                       = sv[k];
    assign rx_src[(k-N_CL)*IDW +: IDW]            = ssrc[k];
    assign rx_payload[(k-N_CL)*PAY_W +: PAY_W]    = spay[k];
  end
endmodule

// File: rtl/ring_bcast_bus_chk.sv
module ring_bcast_bus_chk #(
  parameter int N_CL  = 8,
  parameter int PAY_W = 16,
  parameter int BURST = 2,
  localparam int IDW  = (N_CL > 1) ? $clog2(N_CL) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [N_CL-1:0]       tx_valid,
  input logic [N_CL-1:0]       tx_ready,
  input logic [N_CL-1:0]       rx_valid,
  input logic [N_CL*IDW-1:0]   rx_src,
  input logic [N_CL*PAY_W-1:0] rx_payload
);
  logic [N_CL-1:0] prev_rdy;
  int unsigned     run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_rdy <= '0;
      run      <= 0;
    end else begin
      prev_rdy <= tx_ready;
      if (tx_ready == '0)            run <= 0;
      else if (tx_ready == prev_rdy) run <= run + 1;
      else                           run <= 1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (rx_valid == '0 && (tx_ready >> 1) == '0));

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_ready));

  // R3
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready & ~tx_valid) == '0);

  // R5
  burst_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run <= BURST);

  for (genvar d = 0; d < N_CL - 1; d++) begin : g_relay
    // R9
    relay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid[d] |=> (rx_valid[d+1]
                       && rx_src[(d+1)*IDW +: IDW] == $past(rx_src[d*IDW +: IDW])
                       && rx_payload[(d+1)*PAY_W +: PAY_W] == $past(rx_payload[d*PAY_W +: PAY_W])));
  end
endmodule

bind ring_bcast_bus ring_bcast_bus_chk #(.N_CL(N_CL), .PAY_W(PAY_W), .BURST(BURST)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_src(rx_src), .rx_payload(rx_payload)
);

// File: tb/ring_bcast_bus_bench.sv
module ring_bcast_bus_bench;
  localparam int N     = 8;
  localparam int PW    = 16;
  localparam int BURST = 2;
  localparam int IDW   = $clog2(N);
  localparam int MAXS  = 8192;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    tx_valid;
  logic [N*PW-1:0] tx_payload;
  logic [N-1:0]    tx_ready;
  logic [N-1:0]    rx_valid;
  logic [N*IDW-1:0] rx_src;
  logic [N*PW-1:0] rx_payload;

  ring_bcast_bus #(.N_CL(N), .PAY_W(PW), .BURST(BURST)) u_ring_bcast_bus (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_payload(tx_payload),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_src(rx_src), .rx_payload(rx_payload)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic [11:0] seq [N];
  logic [N-1:0] acc_q = '0;
  int mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  always_comb
    for (int c = 0; c < N; c++) tx_payload[c*PW +: PW] = {c[3:0], seq[c]};

  int s_cyc [MAXS];
  int s_cl  [MAXS];
  logic [PW-1:0] s_pay [MAXS];
  int s_rcv [MAXS];
  int nsend = 0;
  int n = 0;
  int tok = 0;
  int cnt = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", what, act, exp, n);
    end
  endtask

  always @(negedge clk) begin
    logic [N-1:0] busy;
    logic [N-1:0] exp_rdy;
    if (!rst_n) begin
      chk(rx_valid == '0, "R1 rx_valid in reset", int'(rx_valid), 0);
      tok = 0; cnt = 0; n = 0;
      acc_q <= '0;
    end else begin
      busy = '0;
      for (int i = nsend - 1; i >= 0 && (n - s_cyc[i]) <= 2*N + 2; i--)
        for (int k = 0; k < N; k++)
          if (s_cl[i] < k && n == s_cyc[i] + (k - s_cl[i])) busy[k] = 1'b1;
      exp_rdy = '0;
      if (tx_valid[tok] && !busy[tok]) exp_rdy[tok] = 1'b1;
      chk(tx_ready == exp_rdy, "R2 R3 R4 R5 R6 tx_ready", int'(tx_ready), int'(exp_rdy));
      for (int d = 0; d < N; d++) begin
        int hit;
        hit = -1;
        for (int i = nsend - 1; i >= 0 && (n - s_cyc[i]) <= 2*N + 2; i--)
          if (n == s_cyc[i] + 1 + N + d - s_cl[i]) hit = i;
        if (hit < 0) begin
          chk(!rx_valid[d], "R8 spurious rx_valid", int'(rx_valid[d]), 0);
        end else begin
          chk(rx_valid[d], "R7 rx_valid", int'(rx_valid[d]), 1);
          chk(rx_src[d*IDW +: IDW] == IDW'(s_cl[hit]), "R7 rx_src",
              int'(rx_src[d*IDW +: IDW]), s_cl[hit]);
          chk(rx_payload[d*PW +: PW] == s_pay[hit], "R7 rx_payload",
              int'(rx_payload[d*PW +: PW]), int'(s_pay[hit]));
          if (rx_valid[d]) s_rcv[hit]++;
        end
      end
      acc_q <= tx_valid & tx_ready;
      if (exp_rdy != '0 && nsend < MAXS) begin
        s_cyc[nsend] = n; s_cl[nsend] = tok;
        s_pay[nsend] = tx_payload[tok*PW +: PW]; s_rcv[nsend] = 0;
        nsend++;
      end
      if (!tx_valid[tok] || (exp_rdy != '0 && cnt == BURST - 1)) begin
        tok = (tok + 1) % N; cnt = 0;
      end else if (exp_rdy != '0) begin
        cnt++;
      end
      n++;
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    for (int c = 0; c < N; c++) begin
      if (acc_q[c]) seq[c] = seq[c] + 1'b1;
      if (acc_q[c] || !tx_valid[c])
        tx_valid[c] = (mode == 1) ? 1'b1 : (mode == 2) ? (lfsr[c] & lfsr[c+5]) : 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0;
    tx_valid = '0;
    for (int c = 0; c < N; c++) seq[c] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 R4: idle ring, token wanders without takers
    mode = 0;
    repeat (20) step();
    // R3 R7: single post from cluster 3 waits for the token
    tx_valid[3] = 1'b1;
    repeat (3 * N) step();
    // R5 R6: every cluster saturated
    mode = 1;
    repeat (300) step();
    // R2 R8: irregular traffic
    mode = 2;
    repeat (2000) step();
    mode = 0;
    repeat (4 * N) step();
    for (int i = 0; i < nsend; i++)
      chk(s_rcv[i] == N, "R8 delivery count", s_rcv[i], N);
    chk(nsend > 100, "R7 enough traffic", nsend, 100);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n, 0);
    finish_run();
  end
endmodule